// File: doc/BRIEF.md
# Fault-Injectable Two-Input Logic Cell

This block is a single two-input Boolean cell for fault-injection experiments. In normal use it computes the function given by a 4-bit nominal truth table, which is usually held constant (an AND cell uses 4'b1000). An attack port can tamper with the cell in two independent ways. It can replace the whole function with any of the sixteen two-input functions. It can also put a fault on either input wire or on the output wire: invert the value, force it to 0, or force it to 1.

An attack is offered on a cycle where `attack_valid` is high. A one-round attack affects only that cycle. A permanent attack also affects that cycle, and at the clock edge it is written into a sticky register. From then on the cell applies it on every evaluation until a synchronous reset clears it. A later permanent attack overwrites only the fields it makes active, so attacks build up over time. A one-round attack shown on top of a stored attack wins for that cycle, in the fields it makes active.

The cell's output is combinational from its inputs and the stored attack state. The tamper order is fixed: input wire faults first, then the table lookup (the substitute table if one is active, otherwise the nominal one), then the output wire fault.

Top module: `fault_cell_top`

## Requirements
- R1: While `rst` is high at a clock edge, the stored attack state is cleared. After reset, with `attack_valid` low, `out_y` equals `nominal_tt[{in_a,in_b}]`.
- R2: A truth table is indexed by the 2-bit value {a,b}, with a as the high bit. So `out_y` = tt[2*a+b], where a and b are the values after any input wire fault.
- R3: Every wire fault code is 2 bits: 2'b00 leaves the wire alone, 2'b01 inverts it, 2'b10 forces 0 and 2'b11 forces 1.
- R4: Input faults (`fault_a`, `fault_b`) are applied before the lookup. When `subst_en` is active, `subst_tt` replaces `nominal_tt`. The output fault `fault_y` is applied last, to the result of the (possibly substituted) table.
- R5: While `attack_valid` is low and nothing is stored, `subst_en`, `subst_tt`, the fault codes and `attack_persist` have no effect on `out_y`.
- R6: An attack with `attack_valid` high and `attack_persist` low affects `out_y` only in that cycle. It leaves no trace in later cycles.
- R7: An attack with `attack_valid` and `attack_persist` both high affects `out_y` in its own cycle and in every later cycle until reset. At the clock edge it stores only its active fields (substitution when `subst_en` is high, and each fault whose code is not 2'b00). Fields it leaves inactive keep their earlier stored value.
- R8: During a cycle with `attack_valid` high, each active field of the offered attack takes precedence over the stored one. Each inactive field falls back to the stored value.
- R9: A reset removes every stored attack, so `out_y` returns to the nominal function.
- R10: With the nominal AND table and no substitution, none of the 64 combinations of wire faults gives an XOR or XNOR table over the four input pairs. A substitution with 4'b0110 or 4'b1001 gives exactly those tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears stored attacks |
| in_a | input | 1 | Data input a (high index bit) |
| in_b | input | 1 | Data input b (low index bit) |
| nominal_tt | input | 4 | Nominal truth table |
| attack_valid | input | 1 | An attack is offered this cycle |
| attack_persist | input | 1 | 1: permanent attack, 0: one-round attack |
| subst_en | input | 1 | Function substitution active in the offered attack |
| subst_tt | input | 4 | Substitute truth table |
| fault_a | input | 2 | Fault code for input wire a |
| fault_b | input | 2 | Fault code for input wire b |
| fault_y | input | 2 | Fault code for the output wire |
| out_y | output | 1 | Possibly tampered result |

## Verification
The bench sweeps every nominal table, every input pair, every substitute table (and none), and all 64 fault-code combinations as one-round attacks. A design that swapped the index bits, applied the output fault before substitution, or misdecoded a fault code would miss for many entries. Directed sequences check three things: a permanent attack builds up across fields, a one-round attack shown over it wins only for its cycle, and reset clears it. A design that latched one-round attacks, overwrote inactive fields, or let stored state survive reset would diverge there. A further sweep shows that no wire-fault combination turns an AND cell into XOR or XNOR, while a substitution does.

// File: rtl/fault_cell_pkg.sv
package fault_cell_pkg;

    localparam int ARITY   = 2;
    localparam int TT_W    = 1 << ARITY;
    localparam int FCODE_W = 2;
    localparam int N_INW   = ARITY;

    typedef enum logic [FCODE_W-1:0] {
        WF_NONE = 2'b00,
        WF_FLIP = 2'b01,
        WF_ZERO = 2'b10,
        WF_ONE  = 2'b11
    } wire_fault_e;

    typedef logic [TT_W-1:0] truth_t;

    typedef struct packed {
        logic        subst_en;
        truth_t      subst_tt;
        wire_fault_e fa;
        wire_fault_e fb;
        wire_fault_e fy;
    } attack_t;

    localparam attack_t ATTACK_NONE = '{
        subst_en: 1'b0,
        subst_tt: '0,
        fa:       WF_NONE,
        fb:       WF_NONE,
        fy:       WF_NONE
    };

    function automatic logic apply_fault(input logic v, input wire_fault_e code);
        logic r;
        case (code)
            WF_FLIP: r = ~v;
            WF_ZERO: r = 1'b0;
            WF_ONE:  r = 1'b1;
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic tt_lookup(input truth_t tt, input logic a, input logic b);
        return tt[{a, b}];
    endfunction

    // Fields active in 'upper' replace those of 'lower'.
    function automatic attack_t overlay(input attack_t upper, input attack_t lower);
        attack_t r;
        r = lower;
        if (upper.subst_en) begin
            r.subst_en = 1'b1;
            r.subst_tt = upper.subst_tt;
        end
        if (upper.fa != WF_NONE) r.fa = upper.fa;
        if (upper.fb != WF_NONE) r.fb = upper.fb;
        if (upper.fy != WF_NONE) r.fy = upper.fy;
        return r;
    endfunction

    function automatic logic is_clean(input attack_t x);
        return (x == ATTACK_NONE);
    endfunction

endpackage

// File: rtl/fault_sticky_store.sv
module fault_sticky_store
    import fault_cell_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  attack_t incoming,
    output attack_t held
);

    attack_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= ATTACK_NONE;
        end else if (load) begin
            held_q <= overlay(incoming, held_q);
        end
    end

    assign held = held_q;

    AST_STORE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_q)); // R7

    AST_STORE_CLEARED: assert property (@(posedge clk)
        rst |=> is_clean(held_q)); // R9

    AST_STORE_KEEPS_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (load && incoming.fy == WF_NONE) |=> $stable(held_q.fy)); // R7

endmodule

// File: rtl/fault_attack_merge.sv
module fault_attack_merge
    import fault_cell_pkg::*;
(
    input  logic    offer_valid,
    input  attack_t offered,
    input  attack_t held,
    output attack_t effective
);

    always_comb begin
        if (offer_valid) begin
            effective = overlay(offered, held);
        end else begin
            effective = held;
        end
    end

endmodule

// File: rtl/fault_wire_tamper.sv
module fault_wire_tamper
    import fault_cell_pkg::*;
(
    input  logic        wire_in,
    input  wire_fault_e code,
    output logic        wire_out
);

    always_comb begin
        wire_out = apply_fault(wire_in, code);
    end

endmodule

// File: rtl/fault_lut_eval.sv
module fault_lut_eval
    import fault_cell_pkg::*;
(
    input  truth_t nominal,
    input  logic   subst_en,
    input  truth_t subst_tt,
    input  logic   a,
    input  logic   b,
    output logic   y
);

    truth_t active_tt;

    always_comb begin
        active_tt = subst_en ? subst_tt : nominal;
        y         = tt_lookup(active_tt, a, b);
    end

endmodule

// File: rtl/fault_cell_top.sv
module fault_cell_top
    import fault_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_a,
    input  logic               in_b,
    input  logic [TT_W-1:0]    nominal_tt,
    input  logic               attack_valid,
    input  logic               attack_persist,
    input  logic               subst_en,
    input  logic [TT_W-1:0]    subst_tt,
    input  logic [FCODE_W-1:0] fault_a,
    input  logic [FCODE_W-1:0] fault_b,
    input  logic [FCODE_W-1:0] fault_y,
    output logic               out_y
);

    attack_t offered;
    attack_t held;
    attack_t effective;

    logic [N_INW-1:0]  raw_in;
    logic [N_INW-1:0]  tampered_in;
    wire_fault_e       in_code [N_INW];
    logic              lut_y;

    always_comb begin
        offered.subst_en = subst_en;
        offered.subst_tt = subst_tt;
        offered.fa       = wire_fault_e'(fault_a);
        offered.fb       = wire_fault_e'(fault_b);
        offered.fy       = wire_fault_e'(fault_y);
    end

    fault_sticky_store u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (attack_valid && attack_persist),
        .incoming (offered),
        .held     (held)
    );

    fault_attack_merge u_merge (
        .offer_valid (attack_valid),
        .offered     (offered),
        .held        (held),
        .effective   (effective)
    );

    // Input wires: index 1 is a (high table bit), index 0 is b.
    assign raw_in     = {in_a, in_b};
    assign in_code[1] = effective.fa;
    assign in_code[0] = effective.fb;

    for (genvar w = 0; w < N_INW; w++) begin : g_in_wire
        fault_wire_tamper u_in (
            .wire_in  (raw_in[w]),
            .code     (in_code[w]),
            .wire_out (tampered_in[w])
        );
    end

    fault_lut_eval u_lut (
        .nominal  (nominal_tt),
        .subst_en (effective.subst_en),
        .subst_tt (effective.subst_tt),
        .a        (tampered_in[1]),
        .b        (tampered_in[0]),
        .y        (lut_y)
    );

    fault_wire_tamper u_out (
        .wire_in  (lut_y),
        .code     (effective.fy),
        .wire_out (out_y)
    );

    AST_OUT_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
        (effective.fy == WF_ONE) |-> out_y); // R3

    AST_OUT_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
        (effective.fy == WF_ZERO) |-> !out_y); // R3

    AST_CLEAN_IS_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        (!attack_valid && is_clean(held)) |-> (out_y == nominal_tt[{in_a, in_b}])); // R5

    AST_ONE_ROUND_LEAVES_NOTHING: assert property (@(posedge clk) disable iff (rst)
        (attack_valid && !attack_persist && is_clean(held)) |=> is_clean(held)); // R6

    AST_OFFER_WINS: assert property (@(posedge clk) disable iff (rst)
        (attack_valid && subst_en) |-> (effective.subst_tt == subst_tt)); // R8

endmodule

// File: tb/fault_cell_top_tb_top.sv
module fault_cell_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_a, in_b;
    logic [3:0] nominal_tt;
    logic       attack_valid, attack_persist, subst_en;
    logic [3:0] subst_tt;
    logic [1:0] fault_a, fault_b, fault_y;
    logic       out_y;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk; // 250 MHz

    fault_cell_top dut_i (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .nominal_tt(nominal_tt),
        .attack_valid(attack_valid), .attack_persist(attack_persist),
        .subst_en(subst_en), .subst_tt(subst_tt),
        .fault_a(fault_a), .fault_b(fault_b), .fault_y(fault_y), .out_y(out_y)
    );

    function automatic logic m_fault(input logic v, input logic [1:0] c);
        case (c)
            2'b01:   return ~v;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return v;
        endcase
    endfunction

    function automatic logic m_cell(input logic [3:0] nom, input logic a, input logic b,
                                    input logic se, input logic [3:0] st,
                                    input logic [1:0] fa, input logic [1:0] fb,
                                    input logic [1:0] fy);
        logic aa, bb, r;
        logic [3:0] t;
        aa = m_fault(a, fa);
        bb = m_fault(b, fb);
        t  = se ? st : nom;
        r  = t[2 * int'(aa) + int'(bb)];
        return m_fault(r, fy);
    endfunction

    task automatic drive(input logic a, input logic b, input logic [3:0] nom,
                         input logic v, input logic p, input logic se, input logic [3:0] st,
                         input logic [1:0] fa, input logic [1:0] fb, input logic [1:0] fy);
        @(negedge clk);
        in_a = a; in_b = b; nominal_tt = nom;
        attack_valid = v; attack_persist = p; subst_en = se; subst_tt = st;
        fault_a = fa; fault_b = fb; fault_y = fy;
        #1;
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (out_y !== exp) begin
            failures++;
            $display("FAIL %s: out_y=%b expected=%b", tag, out_y, exp);
        end
    endtask

    // Observe the full table over the four input pairs (no attack offered).
    task automatic probe_idle(input logic [3:0] nom, input logic [3:0] exp_tt, input string tag);
        for (int ab = 0; ab < 4; ab++) begin
            drive(ab[1], ab[0], nom, 1'b0, 1'b1, 1'b1, 4'hF, 2'b11, 2'b01, 2'b10);
            check(exp_tt[ab], tag);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_a = 0; in_b = 0; nominal_tt = 4'b1000;
        attack_valid = 0; attack_persist = 0; subst_en = 0; subst_tt = 0;
        fault_a = 0; fault_b = 0; fault_y = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state: AND behaviour (R2 index order)
        probe_idle(4'b1000, 4'b1000, "R1 reset nominal");

        // R5: attack fields ignored while attack_valid low
        for (int nm = 0; nm < 16; nm++) begin
            for (int ab = 0; ab < 4; ab++) begin
                drive(ab[1], ab[0], 4'(nm), 1'b0, ab[0], 1'b1, 4'(~nm), 2'b11, 2'b10, 2'(ab));
                check(m_cell(4'(nm), ab[1], ab[0], 0, 0, 0, 0, 0), "R5 ignored idle");
            end
        end

        // R2 R3 R4 R6: exhaustive one-round sweep
        for (int nm = 0; nm < 16; nm++)
          for (int ab = 0; ab < 4; ab++)
            for (int s = 0; s < 17; s++)
              for (int f = 0; f < 64; f++) begin
                  logic se;
                  logic [3:0] st;
                  se = (s < 16);
                  st = se ? 4'(s) : 4'(nm ^ 5);
                  drive(ab[1], ab[0], 4'(nm), 1'b1, 1'b0, se, st,
                        2'(f >> 4), 2'(f >> 2), 2'(f));
                  check(m_cell(4'(nm), ab[1], ab[0], se, st, 2'(f >> 4), 2'(f >> 2), 2'(f)),
                        "R4 one-round sweep");
              end

        // R6: nothing left behind after one-round attacks
        probe_idle(4'b1000, 4'b1000, "R6 no residue");

        // R10: wire faults alone never yield XOR/XNOR from AND
        for (int f = 0; f < 64; f++) begin
            logic [3:0] seen;
            for (int ab = 0; ab < 4; ab++) begin
                drive(ab[1], ab[0], 4'b1000, 1'b1, 1'b0, 1'b0, 4'b0,
                      2'(f >> 4), 2'(f >> 2), 2'(f));
                seen[ab] = out_y;
            end
            checks++;
            if (seen == 4'b0110 || seen == 4'b1001) begin
                failures++;
                $display("FAIL R10 wire-only table=%b expected=not xor/xnor", seen);
            end
        end
        for (int ab = 0; ab < 4; ab++) begin
            drive(ab[1], ab[0], 4'b1000, 1'b1, 1'b0, 1'b1, 4'b0110, 0, 0, 0);
            check(ab[1] ^ ab[0], "R10 subst xor");
            drive(ab[1], ab[0], 4'b1000, 1'b1, 1'b0, 1'b1, 4'b1001, 0, 0, 0);
            check(~(ab[1] ^ ab[0]), "R10 subst xnor");
        end

        // R7: permanent XOR substitution, effective in its own cycle
        drive(1, 1, 4'b1000, 1'b1, 1'b1, 1'b1, 4'b0110, 0, 0, 0);
        check(1'b0, "R7 permanent own cycle");
        probe_idle(4'b1000, 4'b0110, "R7 permanent xor held");

        // R7: add a force-1 on wire a, substitution kept -> out = ~b
        drive(0, 0, 4'b1000, 1'b1, 1'b1, 1'b0, 4'b0000, 2'b11, 0, 0);
        check(1'b1, "R7 accumulate own cycle");
        probe_idle(4'b1000, 4'b0101, "R7 accumulate held");

        // R8: one-round offer wins for its cycle, then stored state returns
        drive(1, 0, 4'b1000, 1'b1, 1'b0, 1'b1, 4'b0000, 0, 0, 0);
        check(1'b0, "R8 offer table wins");
        drive(0, 1, 4'b1000, 1'b1, 1'b0, 1'b0, 4'b0000, 2'b10, 0, 0);
        check(1'b1, "R8 offer fault wins, stored subst kept");
        drive(0, 1, 4'b1000, 1'b1, 1'b0, 1'b0, 4'b0000, 0, 0, 2'b01);
        check(1'b1, "R8 offer output flip over stored");
        probe_idle(4'b1000, 4'b0101, "R6 stored unchanged after one-round");

        // R9: reset clears all stored attack
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe_idle(4'b1000, 4'b1000, "R9 cleared by reset");
        probe_idle(4'b1110, 4'b1110, "R1 nominal OR after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule